// File: doc/BRIEF.md
# Dual-Channel 7:1 Display Link Serializer

This block is the digital transmit side of a flat-panel display link. Once per pixel period it takes one or two 18-bit RGB pixels and the three LCD timing bits: horizontal sync, vertical sync and data enable. It splits them into 7-bit words and shifts each word out one bit per bit-clock cycle. There are two channels. Each channel has three data lanes and a clock lane, and the clock lane repeats a fixed 7-bit pattern in step with the data.

The block runs on the 7x bit clock. An internal phase counter counts 0 to 6. The load strobe `ld_o` is high in the cycle where the phase is 0. The upstream pixel source holds the pixel and the timing bits valid in that cycle, and they are captured on the rising edge that ends it. Port enable, dual mode and the idle-lane option are sampled only at that same edge.

In single-channel mode only channel A carries data. In dual-channel mode, channel A carries the even pixel on `pix_a_i` and channel B carries the odd pixel on `pix_b_i`. Both channels carry the same timing bits. A lane the mode does not use is either powered down (`oe` low, data 0) or driven with constant zeros (`oe` high, data 0). When the port is disabled, every lane is powered down.

Top module: `panel_link_tx`

## Requirements
- R1: While `rst_ni` is low, all `dat_o`, `dat_oe_o`, `clk_o` and `clk_oe_o` bits are 0.
- R2: `ld_o` is high in exactly one cycle out of every seven, and it is high in the first cycle after reset is released.
- R3: An active clock lane sends 1100011, leftmost bit first. Bit j of the pattern (j = 0 is the leftmost) is on the output in the j+1-th cycle after a load edge, so it lines up with data bit j.
- R4: The pixel layout is R = pix[17:12], G = pix[11:6], B = pix[5:0]. On an active channel, lane 0 sends {R[5:0], G[0]}, lane 1 sends {G[5:1], B[1:0]} and lane 2 sends {B[5:2], hsync, vsync, de}.
- R5: Each 7-bit lane word is sent most significant bit first, one bit per cycle, over the seven cycles that follow its load edge.
- R6: In dual mode, channel B sends `pix_b_i` with the R4 mapping and the same timing bits as channel A, in the same cycles.
- R7: In single mode, channel B is inactive and `pix_b_i` has no effect on any output.
- R8: When port enable is 0 at a load edge, every data lane and clock lane has `oe` 0 and data 0 for the following seven cycles.
- R9: When the port is enabled, each unused lane has data 0. Its `oe` is 1 if `zero_idle_i` was 1 at the load edge, and 0 if it was 0. Active lanes have `oe` 1.
- R10: A change to `port_en_i`, `dual_i` or `zero_idle_i` made between load edges has no effect on the word being sent. It takes effect only at the next load edge.
- R11: Each channel's clock-lane `oe` equals the `oe` of that channel's data lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 7x bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Enables the whole link |
| dual_i | input | 1 | 1 = two channels, 0 = channel A only |
| zero_idle_i | input | 1 | Idle lanes: 1 = drive zeros, 0 = power down |
| pix_a_i | input | 18 | Pixel for channel A (even pixel) |
| pix_b_i | input | 18 | Pixel for channel B (odd pixel) |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| ld_o | output | 1 | High in the cycle whose closing edge captures the inputs |
| dat_o | output | 6 | Serial data lanes; channel c, lane l is at index 3c+l |
| dat_oe_o | output | 6 | Output enable for each data lane |
| clk_o | output | 2 | Serial clock lanes, one per channel |
| clk_oe_o | output | 2 | Output enable for each clock lane |

## Verification
The bench captures the seven bits of every lane in every slot and compares them with words built from the mapping rule. A swapped lane or bit order, or MSB and LSB reversed, shows up at once. Pixel values with walking and all-ones colour fields catch crossed colour bits, and a wrong placement of the sync bits shows up in lane 2. Single-mode slots put all ones on `pix_b_i`, so a design that leaks the channel B pixel would drive ones on channel B. Every combination of port enable and the idle option is tried, to catch `oe` and data gating that is swapped or missing. A directed test toggles port enable in the middle of a slot: a design that applies it at once would cut the word short.

// File: rtl/panel_link_pkg.sv
package panel_link_pkg;
  localparam int COLOR_W = 6;
  localparam int PIX_W   = 3 * COLOR_W;
  localparam int LANES   = 3;
  localparam int CH_N    = 2;
  localparam int SER_W   = (PIX_W + 3) / LANES;
  localparam int PH_W    = $clog2(SER_W);
  localparam logic [SER_W-1:0] CLK_PAT = 7'b1100011;

  typedef logic [SER_W-1:0] word_t;
  typedef logic [PIX_W-1:0] pix_t;

  function automatic word_t lane_word(input int lane, input pix_t p,
                                      input logic hs, input logic vs, input logic de);
    logic [COLOR_W-1:0] r, g, b;
    r = p[3*COLOR_W-1:2*COLOR_W];
    g = p[2*COLOR_W-1:COLOR_W];
    b = p[COLOR_W-1:0];
    case (lane)
      0:       lane_word = {r, g[0]};
      1:       lane_word = {g[5:1], b[1:0]};
      default: lane_word = {b[5:2], hs, vs, de};
    endcase
  endfunction
endpackage

// File: rtl/link_phase.sv
module link_phase
  import panel_link_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic ld_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ph_q <= '0;
    else if (ph_q == PH_W'(SER_W - 1))    ph_q <= '0;
    else                                  ph_q <= ph_q + 1'b1;
  end

  assign ld_o = (ph_q == '0);
endmodule

// File: rtl/lane_map.sv
module lane_map
  import panel_link_pkg::*;
(
  input  pix_t  pix_i,
  input  logic  hs_i,
  input  logic  vs_i,
  input  logic  de_i,
  output word_t word_o [LANES]
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign word_o[l] = lane_word(l, pix_i, hs_i, vs_i, de_i);
  end
endmodule

// File: rtl/lane_ser.sv
module lane_ser #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         act_i,
  input  logic         hold_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o,
  output logic         oe_o
);
  logic [W-1:0] sh_q;
  logic         oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= act_i ? word_i : '0;
      oe_q <= act_i | hold_i;   // idle lane kept driving zeros
    end else begin
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign bit_o = sh_q[W-1];
  assign oe_o  = oe_q;
endmodule

// File: rtl/panel_link_tx.sv
module panel_link_tx
  import panel_link_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    port_en_i,
  input  logic                    dual_i,
  input  logic                    zero_idle_i,
  input  logic [PIX_W-1:0]        pix_a_i,
  input  logic [PIX_W-1:0]        pix_b_i,
  input  logic                    hsync_i,
  input  logic                    vsync_i,
  input  logic                    de_i,
  output logic                    ld_o,
  output logic [CH_N*LANES-1:0]   dat_o,
  output logic [CH_N*LANES-1:0]   dat_oe_o,
  output logic [CH_N-1:0]         clk_o,
  output logic [CH_N-1:0]         clk_oe_o
);
  logic ld;
  logic hold;
  pix_t pix_ch [CH_N];

  assign pix_ch[0] = pix_a_i;
  assign pix_ch[1] = pix_b_i;
  assign hold      = port_en_i & zero_idle_i;
  assign ld_o      = ld;

  link_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_o   (ld)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic  act;
    word_t words [LANES];

    assign act = port_en_i & ((c == 0) | dual_i);

    lane_map u_map (
      .pix_i  (pix_ch[c]),
      .hs_i   (hsync_i),
      .vs_i   (vsync_i),
      .de_i   (de_i),
      .word_o (words)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_dat
      lane_ser #(.W(SER_W)) u_ser (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (ld),
        .act_i  (act),
        .hold_i (hold),
        .word_i (words[l]),
        .bit_o  (dat_o[c*LANES+l]),
        .oe_o   (dat_oe_o[c*LANES+l])
      );
    end

    lane_ser #(.W(SER_W)) u_clk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (ld),
      .act_i  (act),
      .hold_i (hold),
      .word_i (CLK_PAT),
      .bit_o  (clk_o[c]),
      .oe_o   (clk_oe_o[c])
    );
  end
endmodule

// File: rtl/panel_link_tx_chk.sv
module panel_link_tx_chk
  import panel_link_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ld_o,
  input logic [CH_N*LANES-1:0] dat_o,
  input logic [CH_N*LANES-1:0] dat_oe_o,
  input logic [CH_N-1:0]       clk_o,
  input logic [CH_N-1:0]       clk_oe_o
);
  logic [PH_W-1:0] cnt_q;
  int unsigned     slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (cnt_q == PH_W'(SER_W - 1))   cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  // index of the pattern bit on the wire in this cycle
  assign slot = (int'(cnt_q) + SER_W - 1) % SER_W;

  p_ld_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o == (cnt_q == '0));

  p_clk_pat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_oe_o[0] |-> clk_o[0] == CLK_PAT[SER_W-1-slot]);

  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dat_o & ~dat_oe_o) == '0) && ((clk_o & ~clk_oe_o) == '0));

  p_b_needs_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_oe_o[LANES] |-> dat_oe_o[0]);

  p_oe_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_o |=> $stable(dat_oe_o) && $stable(clk_oe_o));

  p_clk_oe_track_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_oe_o == {dat_oe_o[LANES], dat_oe_o[0]});
endmodule

bind panel_link_tx panel_link_tx_chk u_chk (.*);

// File: tb/sim_panel_link_tx.sv
module sim_panel_link_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        port_en_i = 1'b0, dual_i = 1'b0, zero_idle_i = 1'b0;
  logic [17:0] pix_a_i = '0, pix_b_i = '0;
  logic        hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
  logic        ld_o;
  logic [5:0]  dat_o, dat_oe_o;
  logic [1:0]  clk_o, clk_oe_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  panel_link_tx u0 (.*);

  // {en, dual, zero, hs, vs, de, pix_a[17:0], pix_b[17:0]}
  localparam logic [41:0] VEC [8] = '{
    {6'b100_101, 18'h2A5C3, 18'h3FFFF},
    {6'b110_011, 18'h00001, 18'h20000},
    {6'b111_110, 18'h3F000, 18'h00FC0},
    {6'b101_111, 18'h0003F, 18'h3FFFF},
    {6'b011_111, 18'h3FFFF, 18'h3FFFF},
    {6'b000_101, 18'h15555, 18'h2AAAA},
    {6'b110_110, 18'h12345, 18'h2ABCD},
    {6'b100_000, 18'h3FFFF, 18'h3FFFF}
  };

  function automatic logic [6:0] exp_word(input int l, input logic [17:0] p,
                                          input logic hs, input logic vs, input logic de);
    case (l)
      0:       return {p[17:12], p[6]};
      1:       return {p[11:7], p[1:0]};
      default: return {p[5:2], hs, vs, de};
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [6:0] got,
                     input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [41:0] v);
    {port_en_i, dual_i, zero_idle_i, hsync_i, vsync_i, de_i} = v[41:36];
    pix_a_i = v[35:18];
    pix_b_i = v[17:0];
  endtask

  // caller sits on a negedge with ld_o high
  task automatic run_slot(input logic [41:0] v, input bit toggle_mid, input string req);
    logic [6:0] cap [8];
    logic [7:0] oe;
    logic en, dual, zero, act, hs, vs, de;
    drive(v);
    {en, dual, zero, hs, vs, de} = v[41:36];
    checks++;
    if (ld_o !== 1'b1) begin
      errors++;
      $display("FAIL R2 ld_o at slot start got %b expected 1", ld_o);
    end
    for (int j = 0; j < 7; j++) begin
      @(negedge clk_i);
      if (toggle_mid && j == 2) begin
        port_en_i   = ~port_en_i;
        zero_idle_i = ~zero_idle_i;
        dual_i      = ~dual_i;
      end
      if (j == 0) oe = {clk_oe_o, dat_oe_o};
      for (int k = 0; k < 6; k++) cap[k][6-j] = dat_o[k];
      cap[6][6-j] = clk_o[0];
      cap[7][6-j] = clk_o[1];
      if (j < 6) begin
        checks++;
        if (ld_o !== 1'b0) begin
          errors++;
          $display("FAIL R2 ld_o mid slot got %b expected 0", ld_o);
        end
      end
    end
    for (int c = 0; c < 2; c++) begin
      act = en & ((c == 0) | dual);
      for (int l = 0; l < 3; l++) begin
        chk(c == 0 ? "R4 R5" : (dual ? "R6" : "R7"), $sformatf("%s data ch%0d lane%0d", req, c, l),
            cap[c*3+l], act ? exp_word(l, c == 0 ? v[35:18] : v[17:0], hs, vs, de) : 7'd0);
        chk(en ? "R9" : "R8", $sformatf("%s oe ch%0d lane%0d", req, c, l),
            {6'd0, oe[c*3+l]}, {6'd0, act | (en & zero)});
      end
      chk("R3", $sformatf("%s clock lane ch%0d", req, c), cap[6+c], act ? 7'b1100011 : 7'd0);
      chk("R11", $sformatf("%s clock oe ch%0d", req, c), {6'd0, oe[6+c]}, {6'd0, act | (en & zero)});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if ({dat_o, dat_oe_o, clk_o, clk_oe_o} !== 16'd0) begin
      errors++;
      $display("FAIL R1 outputs in reset got %h expected 0", {dat_o, dat_oe_o, clk_o, clk_oe_o});
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) run_slot(VEC[i], 1'b0, $sformatf("vec%0d", i));
    // R10: config flips mid slot, word finishes untouched
    run_slot({6'b110_101, 18'h0F0F0, 18'h30303}, 1'b1, "R10 mid-toggle");
    // R10: flipped config (port off) now takes effect
    run_slot({6'b001_101, 18'h0F0F0, 18'h30303}, 1'b0, "R10 after");
    // R7: same single slot, different pix_b, same outputs
    run_slot({6'b101_010, 18'h1C71C, 18'h00000}, 1'b0, "R7 pixb0");
    run_slot({6'b101_010, 18'h1C71C, 18'h3FFFF}, 1'b0, "R7 pixb1");
    // R1: reset mid run clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    checks++;
    if ({dat_o, dat_oe_o, clk_o, clk_oe_o} !== 16'd0 || ld_o !== 1'b1) begin
      errors++;
      $display("FAIL R1 outputs after reset got %h/%b expected 0/1",
               {dat_o, dat_oe_o, clk_o, clk_oe_o}, ld_o);
    end
    rst_ni = 1'b1;
    run_slot({6'b110_000, 18'h2DB6D, 18'h12492}, 1'b0, "R2 post-reset");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule